// File: doc/BRIEF.md
# Single-Wire Extreme-Value Collector

This block links a group of sensor-node interfaces to one collector over a single shared request line. Each node holds an unsigned digital reading. A start pulse captures every reading. A shared down-counter then sweeps from the largest code to zero. A node raises the line in the one cycle in which the sweep count equals its captured reading. As a result, the readings arrive at the collector already ordered from largest to smallest, and the collector needs no comparator network.

The collector turns each line assertion back into a value by taking the count in that cycle. It keeps only the first K values it sees, which are the K largest distinct readings, and drops the rest. The line is the OR of all node requests, so nodes with equal readings merge into one pulse. A load-sense signal reports when more than one node drove the pulse, and that value's slot carries a tie bit. At the end of the sweep the block pulses a done output. A host then reads the slots through a small indexed port.

Top module: `xval_wire_net`

## Requirements
- R1: After reset, busy_o and done_o are 0 and every slot reads with rd_valid_o = 0.
- R2: A start accepted while idle keeps busy_o high for exactly 2^CODE_W cycles. The count falls by one each cycle, from 2^CODE_W-1 to 0. done_o is then high for exactly one cycle, the first cycle after busy_o falls.
- R3: wire_o is high only while busy_o is high. In the k-th busy cycle (k counted from 0), wire_o is high exactly when some node's captured reading equals 2^CODE_W-1-k. This gives exactly one pulse per distinct reading.
- R4: When done_o is high, slot i (rd_idx_i = i) holds the (i+1)-th largest distinct captured reading, so slot 0 holds the maximum.
- R5: When there are fewer than TOP_K distinct readings, the slots beyond the last one found read rd_valid_o = 0. Valid slots are contiguous from slot 0.
- R6: rd_tie_o of a valid slot is 1 exactly when two or more nodes captured that slot's value. It is 0 when only one node did.
- R7: Readings are captured on the cycle a start is accepted. Changes to reading_i during a sweep do not affect wire_o or the slots.
- R8: A start pulse while busy_o is high is ignored. The sweep in progress continues and ends at its normal time.
- R9: Each accepted start clears all slots, so results from a previous sweep never remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a sweep (ignored while busy) |
| reading_i | input | N_NODES*CODE_W | Node readings, node n in bits [n*CODE_W +: CODE_W] |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle pulse after the sweep ends |
| wire_o | output | 1 | Shared request line (OR of node requests) |
| rd_idx_i | input | max(1,clog2(TOP_K)) | Slot to read |
| rd_valid_o | output | 1 | Selected slot holds a value |
| rd_value_o | output | CODE_W | Value in the selected slot |
| rd_tie_o | output | 1 | Selected value was held by more than one node |

## Verification
The bench times every line pulse against the sweep position and targets the boundary codes: the all-ones code, which must appear in the very first busy cycle, and zero, which must appear in the last. An off-by-one in the counter would shift or lose these. Rounds with shared readings catch a collector that stores a merged pulse twice or mislabels the tie bit. A round in which all nodes share one value checks that unused slots stay invalid, and it also exposes stale slots left from a fuller earlier round. Mid-sweep changes to the readings and a second start pulse during a sweep would cause extra pulses or a longer sweep in a design that recaptured readings or restarted.

// File: rtl/xvw_pkg.sv
package xvw_pkg;

    typedef enum logic {
        SWEEP_IDLE = 1'b0,
        SWEEP_RUN  = 1'b1
    } sweep_mode_e;

endpackage

// File: rtl/xvw_sweep.sv
module xvw_sweep
    import xvw_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              accept_o,
    output logic              active_o,
    output logic [CODE_W-1:0] count_o,
    output logic              done_o
);

    localparam logic [CODE_W-1:0] TOP_CODE = {CODE_W{1'b1}};

    typedef struct packed {
        sweep_mode_e       mode;
        logic [CODE_W-1:0] count;
        logic              done;
    } sweep_t;

    sweep_t st_d, st_q;
    logic   accept_d;

    always_comb begin
        st_d     = st_q;
        st_d.done = 1'b0;
        accept_d = start_i && (st_q.mode == SWEEP_IDLE);
        if (accept_d) begin
            st_d.mode  = SWEEP_RUN;
            st_d.count = TOP_CODE;
        end else if (st_q.mode == SWEEP_RUN) begin
            if (st_q.count == '0) begin
                st_d.mode = SWEEP_IDLE;
                st_d.done = 1'b1;
            end else begin
                st_d.count = st_q.count - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: SWEEP_IDLE, count: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign accept_o = accept_d;
    assign active_o = (st_q.mode == SWEEP_RUN);
    assign count_o  = st_q.count;
    assign done_o   = st_q.done;

    // R2: count falls by one per cycle within a sweep
    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && $past(active_o)) |-> (count_o == $past(count_o) - 1'b1));

    // R2: done is a single-cycle pulse, never during a sweep
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!active_o && $past(active_o)) ##1 !done_o);

    // R8: start inside a sweep does not restart the count
    p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && start_i && count_o != '0) |=> (active_o && count_o == $past(count_o) - 1'b1));

endmodule

// File: rtl/xvw_node.sv
module xvw_node #(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic              active_i,
    input  logic [CODE_W-1:0] reading_i,
    input  logic [CODE_W-1:0] count_i,
    output logic              req_o
);

    logic [CODE_W-1:0] held_d, held_q;

    always_comb begin
        held_d = held_q;
        if (accept_i) begin
            held_d = reading_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= '0;
        end else begin
            held_q <= held_d;
        end
    end

    assign req_o = active_i && (held_q == count_i);

    // R7: captured reading is frozen for the whole sweep
    p_hold_reading_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && !accept_i) |=> $stable(held_q));

    // R3: a node requests in one cycle only
    p_req_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |=> !req_o);

endmodule

// File: rtl/xvw_collector.sv
module xvw_collector #(
    parameter int CODE_W = 6,
    parameter int TOP_K  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   accept_i,
    input  logic                   hit_i,
    input  logic                   multi_i,
    input  logic [CODE_W-1:0]      count_i,
    input  logic [IDX_W-1:0]       rd_idx_i,
    output logic                   rd_valid_o,
    output logic [CODE_W-1:0]      rd_value_o,
    output logic                   rd_tie_o
);

    localparam int IDX_W  = (TOP_K > 1) ? $clog2(TOP_K) : 1;
    localparam int FILL_W = $clog2(TOP_K + 1);
    localparam logic [FILL_W-1:0] FULL = FILL_W'(TOP_K);

    typedef struct packed {
        logic [TOP_K-1:0]             valid;
        logic [TOP_K-1:0]             tie;
        logic [TOP_K-1:0][CODE_W-1:0] value;
        logic [FILL_W-1:0]            fill;
    } slots_t;

    slots_t sl_d, sl_q;

    always_comb begin
        sl_d = sl_q;
        if (accept_i) begin
            sl_d = '0;
        end else if (hit_i && sl_q.fill < FULL) begin
            for (int i = 0; i < TOP_K; i++) begin
                if (FILL_W'(i) == sl_q.fill) begin
                    sl_d.valid[i] = 1'b1;
                    sl_d.tie[i]   = multi_i;
                    sl_d.value[i] = count_i;
                end
            end
            sl_d.fill = sl_q.fill + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sl_q <= '0;
        end else begin
            sl_q <= sl_d;
        end
    end

    always_comb begin
        rd_valid_o = 1'b0;
        rd_tie_o   = 1'b0;
        rd_value_o = '0;
        for (int i = 0; i < TOP_K; i++) begin
            if (IDX_W'(i) == rd_idx_i) begin
                rd_valid_o = sl_q.valid[i];
                rd_tie_o   = sl_q.tie[i];
                rd_value_o = sl_q.value[i];
            end
        end
    end

    generate
        for (genvar g = 0; g + 1 < TOP_K; g++) begin : g_order
            // R4: stored values strictly descend
            p_descending_r4: assert property (@(posedge clk) disable iff (!rst_n)
                sl_q.valid[g+1] |-> (sl_q.valid[g] && sl_q.value[g] > sl_q.value[g+1]));
        end
        for (genvar g = 0; g < TOP_K; g++) begin : g_tie
            // R6: tie bit only on a filled slot
            p_tie_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
                sl_q.tie[g] |-> sl_q.valid[g]);
        end
    endgenerate

    // R9: an accepted start leaves every slot empty
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        accept_i |=> (sl_q.valid == '0));

endmodule

// File: rtl/xval_wire_net.sv
module xval_wire_net #(
    parameter int N_NODES = 6,
    parameter int CODE_W  = 6,
    parameter int TOP_K   = 4,
    localparam int IDX_W  = (TOP_K > 1) ? $clog2(TOP_K) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic [N_NODES*CODE_W-1:0]   reading_i,
    output logic                        busy_o,
    output logic                        done_o,
    output logic                        wire_o,
    input  logic [IDX_W-1:0]            rd_idx_i,
    output logic                        rd_valid_o,
    output logic [CODE_W-1:0]           rd_value_o,
    output logic                        rd_tie_o
);

    logic              accept;
    logic              active;
    logic [CODE_W-1:0] count;
    logic [N_NODES-1:0] req;
    logic              multi;

    xvw_sweep #(.CODE_W(CODE_W)) u_sweep (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .accept_o (accept),
        .active_o (active),
        .count_o  (count),
        .done_o   (done_o)
    );

    generate
        for (genvar n = 0; n < N_NODES; n++) begin : g_node
            xvw_node #(.CODE_W(CODE_W)) u_node (
                .clk       (clk),
                .rst_n     (rst_n),
                .accept_i  (accept),
                .active_i  (active),
                .reading_i (reading_i[n*CODE_W +: CODE_W]),
                .count_i   (count),
                .req_o     (req[n])
            );
        end
    endgenerate

    // shared line and its load sense (more than one driver pulling)
    assign wire_o = |req;
    assign multi  = ($countones(req) > 1);
    assign busy_o = active;

    xvw_collector #(.CODE_W(CODE_W), .TOP_K(TOP_K)) u_coll (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_i   (accept),
        .hit_i      (wire_o),
        .multi_i    (multi),
        .count_i    (count),
        .rd_idx_i   (rd_idx_i),
        .rd_valid_o (rd_valid_o),
        .rd_value_o (rd_value_o),
        .rd_tie_o   (rd_tie_o)
    );

    // R3: the line is quiet outside a sweep
    p_wire_in_sweep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wire_o |-> busy_o);

    // R1: nothing happens until a start is given after reset
    p_idle_until_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> !busy_o);

endmodule

// File: tb/sim_xval_wire_net.sv
`timescale 1ns/1ps
module sim_xval_wire_net;

    localparam int N  = 6;
    localparam int W  = 6;
    localparam int K  = 4;
    localparam int MAXC = (1 << W) - 1;

    typedef struct {
        bit v;
        bit t;
        int val;
    } slot_exp_t;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start_i = 1'b0;
    logic [N*W-1:0]     reading_i = '0;
    logic               busy_o, done_o, wire_o;
    logic [1:0]         rd_idx_i = '0;
    logic               rd_valid_o, rd_tie_o;
    logic [W-1:0]       rd_value_o;

    int n_checks = 0;
    int n_fail   = 0;
    int rounds_seen = 0;
    bit finished = 0;

    slot_exp_t slot_q[$];
    int        pulse_q[$];

    always #4 clk = ~clk;

    xval_wire_net #(.N_NODES(N), .CODE_W(W), .TOP_K(K)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .reading_i(reading_i),
        .busy_o(busy_o), .done_o(done_o), .wire_o(wire_o),
        .rd_idx_i(rd_idx_i), .rd_valid_o(rd_valid_o),
        .rd_value_o(rd_value_o), .rd_tie_o(rd_tie_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // driver: computes expectations, pushes them, then runs the sweep
    task automatic run_round(input int vals[N], input bit mid_change, input bit extra_start);
        int filled = 0;
        int target;
        for (int v = MAXC; v >= 0; v--) begin
            int cnt = 0;
            for (int n = 0; n < N; n++) if (vals[n] == v) cnt++;
            if (cnt > 0) begin
                pulse_q.push_back(v);
                if (filled < K) begin
                    slot_q.push_back('{v: 1'b1, t: (cnt > 1), val: v});
                    filled++;
                end
            end
        end
        for (int i = filled; i < K; i++) slot_q.push_back('{v: 1'b0, t: 1'b0, val: 0});
        target = rounds_seen + 1;
        @(negedge clk);
        for (int n = 0; n < N; n++) reading_i[n*W +: W] = W'(vals[n]);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (mid_change) reading_i = ~reading_i;   // R7 stimulus
        if (extra_start) begin
            repeat (5) @(negedge clk);
            start_i = 1'b1;                      // R8 stimulus
            @(negedge clk);
            start_i = 1'b0;
        end
        while (rounds_seen < target) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // monitor: times pulses and compares slots at done
    initial begin : monitor
        bit in_round = 0;
        int k = 0;
        forever begin
            @(negedge clk);
            if (busy_o) begin
                if (!in_round) begin
                    in_round = 1;
                    k = 0;
                end
                if (wire_o) begin
                    if (pulse_q.size() == 0) check("R3 unexpected pulse", MAXC - k, -1);
                    else check("R3 pulse timing", MAXC - k, pulse_q.pop_front());
                end
                k++;
            end else if (in_round) begin
                in_round = 0;
                check("R2 sweep length", k, MAXC + 1);
                check("R2 done pulse", int'(done_o), 1);
                check("R3 pulses remaining", pulse_q.size(), 0);
                pulse_q.delete();
                for (int i = 0; i < K; i++) begin
                    slot_exp_t e;
                    rd_idx_i = 2'(i);
                    #0.2;
                    if (slot_q.size() == 0) begin
                        check("R4 no expectation", 0, 1);
                    end else begin
                        e = slot_q.pop_front();
                        if (e.v) begin
                            check("R4 slot valid", int'(rd_valid_o), 1);
                            check("R4 slot value", int'(rd_value_o), e.val);
                            check("R6 tie bit", int'(rd_tie_o), int'(e.t));
                        end else begin
                            check("R5 empty slot", int'(rd_valid_o), 0);
                        end
                    end
                end
                @(negedge clk);
                check("R2 done single", int'(done_o), 0);
                rounds_seen++;
            end
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
        end
    end

    initial begin : main
        int v[N];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy after reset", int'(busy_o), 0);
        check("R1 done after reset", int'(done_o), 0);
        for (int i = 0; i < K; i++) begin
            rd_idx_i = 2'(i);
            #0.2;
            check("R1 slot empty after reset", int'(rd_valid_o), 0);
        end
        repeat (3) @(negedge clk);
        check("R1 idle without start", int'(busy_o), 0);

        // distinct readings including the top code (R3, R4)
        v = '{63, 10, 40, 5, 22, 41};
        run_round(v, 0, 0);
        // shared readings and code zero (R6, R3)
        v = '{30, 30, 12, 0, 30, 7};
        run_round(v, 0, 0);
        // all equal: fewer distinct than K, previous slots must clear (R5, R9)
        v = '{9, 9, 9, 9, 9, 9};
        run_round(v, 0, 0);
        // readings change mid-sweep (R7)
        v = '{3, 50, 3, 50, 50, 3};
        run_round(v, 1, 0);
        // start repeated during sweep (R8)
        v = '{1, 2, 62, 17, 33, 2};
        run_round(v, 0, 1);
        // pseudo-random rounds with mixed features
        for (int r = 0; r < 6; r++) begin
            for (int n = 0; n < N; n++) v[n] = int'($urandom_range(0, (r < 3) ? MAXC : 7));
            run_round(v, r[0], r[1]);
        end
        finished = 1;
        summary();
    end

endmodule